// File: doc/BRIEF.md
# LIN Single-Frame Receive Buffer with Overrun Policy

This block holds one received LIN frame (identifier, data length and up to eight data bytes) between the protocol engine and software. The protocol engine presents a completed frame with a one-cycle strobe and a flag that says whether the frame passed its checks. The first good frame into an empty buffer is stored and marks the buffer full. Software reads the stored contents and then pulses a release strobe to free the buffer.

A good frame that arrives while the buffer is still full is an overrun. A sticky overrun flag is raised. A lock-mode input decides which frame is lost. With lock mode off, the newest frame replaces the stored one. With lock mode on, the newest frame is dropped and the older frame stays readable. Software clears the overrun flag with a write-one-to-clear strobe.

Top module: `lin_rxbuf_ovr`

## Requirements
- R1: After reset, the full flag and the overrun flag are 0, and the stored identifier, length and data are all zero.
- R2: A good frame (`frm_valid`=1 and `frm_ok`=1) that arrives while the buffer is empty is stored, and the full flag is set. Both are visible on the outputs in the cycle after the strobe.
- R3: A good frame that arrives while the full flag is set, with no release in the same cycle, sets the overrun flag in the next cycle. The full flag stays set.
- R4: With `lock_mode`=0, an overrunning frame replaces the stored identifier, length and data.
- R5: With `lock_mode`=1, an overrunning frame is discarded, and the stored identifier, length and data are left unchanged.
- R6: `sw_release`=1 clears the full flag. A good frame in the same cycle is accepted as if the buffer were empty: it is stored, the full flag is set and no overrun is raised. A release with no frame leaves the full flag at 0.
- R7: The overrun flag stays set until `ovr_clear`=1. If a clear and a new overrun fall in the same cycle, the flag stays set. A clear with no overrun brings the flag to 0 in the next cycle.
- R8: A frame with `frm_valid`=1 and `frm_ok`=0 changes no output: it does not change the stored frame, the full flag or the overrun flag.
- R9: Data byte k sits at bits [8k+7:8k] of `frm_data` and `buf_data`, and byte 0 is the first data byte. The stored length is 1 to 8. Every byte k with k >= length reads as zero, whatever the protocol engine presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | One-cycle strobe: frame completed by the protocol engine |
| frm_ok | input | 1 | Frame passed its checksum and framing checks |
| frm_id | input | 6 | Received identifier |
| frm_len | input | 4 | Data byte count, 1 to 8 |
| frm_data | input | 64 | Data bytes, byte k at bits [8k+7:8k] |
| sw_release | input | 1 | Software has read the buffer; frees it |
| ovr_clear | input | 1 | Write-one-to-clear for the overrun flag |
| lock_mode | input | 1 | 1: keep the oldest frame on overrun; 0: keep the newest |
| buf_id | output | 6 | Stored identifier |
| buf_len | output | 4 | Stored data length |
| buf_data | output | 64 | Stored data, unused bytes zero |
| buf_full | output | 1 | Buffer holds an unread frame |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The bench covers every data length from 1 to 8 in both lock modes. For each combination it drives a fill, then an overrun, then a clear.

A design with the lock policy inverted would show the wrong frame after the overrun. A design that does not zero the unused bytes would leak the bytes presented beyond the length.

The bench also targets three single-cycle collisions:
- A release and a frame in the same cycle. A design that checks the full flag before applying the release would report a false overrun.
- A clear and an overrun in the same cycle. A design that gives the clear priority would lose the overrun.
- A rejected frame that arrives while the buffer is full. A design that does not gate on `frm_ok` would count a false overrun or corrupt the stored frame.

// File: rtl/lin_rxbuf_pkg.sv
package lin_rxbuf_pkg;
    localparam int DEF_ID_W    = 6;
    localparam int DEF_LEN_W   = 4;
    localparam int DEF_BYTES   = 8;
    localparam int DEF_BYTE_W  = 8;

    // What the buffer does with the frame on the input this cycle
    typedef enum logic [1:0] {
        ACT_NONE      = 2'd0,
        ACT_STORE     = 2'd1,
        ACT_OVERWRITE = 2'd2,
        ACT_DISCARD   = 2'd3
    } rx_action_e;
endpackage

// File: rtl/lin_rxbuf_policy.sv
module lin_rxbuf_policy
    import lin_rxbuf_pkg::*;
(
    input  logic       good,
    input  logic       full_q,
    input  logic       release_i,
    input  logic       lock_i,
    output rx_action_e action,
    output logic       ovr_set,
    output logic       full_next
);
    logic full_eff;

    always_comb begin
        // A release in this cycle frees the buffer before the new frame is judged
        full_eff  = full_q & ~release_i;
        ovr_set   = good & full_eff;
        full_next = full_eff | good;
        if (!good)         action = ACT_NONE;
        else if (!full_eff) action = ACT_STORE;
        else if (lock_i)   action = ACT_DISCARD;
        else               action = ACT_OVERWRITE;
    end
endmodule

// File: rtl/lin_rxbuf_mask.sv
module lin_rxbuf_mask #(
    parameter int N_BYTES = 8,
    parameter int BYTE_W  = 8,
    parameter int LEN_W   = 4
) (
    input  logic [LEN_W-1:0]          len,
    input  logic [N_BYTES*BYTE_W-1:0] din,
    output logic [N_BYTES*BYTE_W-1:0] dout
);
    for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
        assign dout[i*BYTE_W +: BYTE_W] =
            (32'(i) < 32'(len)) ? din[i*BYTE_W +: BYTE_W] : '0;
    end
endmodule

// File: rtl/lin_rxbuf_ovr.sv
module lin_rxbuf_ovr
    import lin_rxbuf_pkg::*;
#(
    parameter int ID_W    = DEF_ID_W,
    parameter int LEN_W   = DEF_LEN_W,
    parameter int N_BYTES = DEF_BYTES,
    parameter int BYTE_W  = DEF_BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frm_valid,
    input  logic                      frm_ok,
    input  logic [ID_W-1:0]           frm_id,
    input  logic [LEN_W-1:0]          frm_len,
    input  logic [N_BYTES*BYTE_W-1:0] frm_data,
    input  logic                      sw_release,
    input  logic                      ovr_clear,
    input  logic                      lock_mode,
    output logic [ID_W-1:0]           buf_id,
    output logic [LEN_W-1:0]          buf_len,
    output logic [N_BYTES*BYTE_W-1:0] buf_data,
    output logic                      buf_full,
    output logic                      ovr_flag
);
    localparam int DATA_W = N_BYTES * BYTE_W;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
    } state_t;

    state_t          st_d, st_q;
    logic            good;
    rx_action_e      action;
    logic            ovr_set;
    logic            full_next;
    logic [DATA_W-1:0] data_masked;

    assign good = frm_valid & frm_ok;

    lin_rxbuf_policy u_policy (
        .good      (good),
        .full_q    (st_q.full),
        .release_i (sw_release),
        .lock_i    (lock_mode),
        .action    (action),
        .ovr_set   (ovr_set),
        .full_next (full_next)
    );

    lin_rxbuf_mask #(
        .N_BYTES (N_BYTES),
        .BYTE_W  (BYTE_W),
        .LEN_W   (LEN_W)
    ) u_mask (
        .len  (frm_len),
        .din  (frm_data),
        .dout (data_masked)
    );

    always_comb begin
        st_d      = st_q;
        st_d.full = full_next;
        // A new overrun wins over a clear in the same cycle
        st_d.ovr  = ovr_set | (st_q.ovr & ~ovr_clear);
        if (action == ACT_STORE || action == ACT_OVERWRITE) begin
            st_d.id   = frm_id;
            st_d.len  = frm_len;
            st_d.data = data_masked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_id   = st_q.id;
    assign buf_len  = st_q.len;
    assign buf_data = st_q.data;
    assign buf_full = st_q.full;
    assign ovr_flag = st_q.ovr;
endmodule

// File: rtl/lin_rxbuf_ovr_chk.sv
module lin_rxbuf_ovr_chk #(
    parameter int ID_W    = 6,
    parameter int LEN_W   = 4,
    parameter int N_BYTES = 8,
    parameter int BYTE_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      frm_valid,
    input logic                      frm_ok,
    input logic                      sw_release,
    input logic                      ovr_clear,
    input logic                      lock_mode,
    input logic [ID_W-1:0]           buf_id,
    input logic [LEN_W-1:0]          buf_len,
    input logic [N_BYTES*BYTE_W-1:0] buf_data,
    input logic                      buf_full,
    input logic                      ovr_flag
);
    logic good;
    logic tail_dirty;
    assign good = frm_valid & frm_ok;

    always_comb begin
        tail_dirty = 1'b0;
        for (int i = 0; i < N_BYTES; i++)
            if (32'(i) >= 32'(buf_len) && buf_data[i*BYTE_W +: BYTE_W] != '0)
                tail_dirty = 1'b1;
    end

    p_fill_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_full && good) |=> buf_full);

    p_overrun_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !sw_release && good) |=> (ovr_flag && buf_full));

    p_lock_keeps_old_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !sw_release && good && lock_mode)
        |=> ($stable(buf_id) && $stable(buf_len) && $stable(buf_data)));

    p_release_no_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_release && !ovr_flag && !good) |=> (!buf_full && !ovr_flag));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clear) |=> ovr_flag);

    p_bad_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!good && !sw_release && !ovr_clear)
        |=> ($stable(buf_full) && $stable(ovr_flag) && $stable(buf_data) && $stable(buf_id)));

    p_tail_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tail_dirty);
endmodule

bind lin_rxbuf_ovr lin_rxbuf_ovr_chk #(
    .ID_W    (ID_W),
    .LEN_W   (LEN_W),
    .N_BYTES (N_BYTES),
    .BYTE_W  (BYTE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid  (frm_valid),
    .frm_ok     (frm_ok),
    .sw_release (sw_release),
    .ovr_clear  (ovr_clear),
    .lock_mode  (lock_mode),
    .buf_id     (buf_id),
    .buf_len    (buf_len),
    .buf_data   (buf_data),
    .buf_full   (buf_full),
    .ovr_flag   (ovr_flag)
);

// File: tb/lin_rxbuf_ovr_test.sv
`timescale 1ns/1ps
module lin_rxbuf_ovr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 0, frm_ok = 0, sw_release = 0, ovr_clear = 0, lock_mode = 0;
    logic [5:0]  frm_id = '0;
    logic [3:0]  frm_len = '0;
    logic [63:0] frm_data = '0;
    logic [5:0]  buf_id;
    logic [3:0]  buf_len;
    logic [63:0] buf_data;
    logic        buf_full, ovr_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    logic [5:0]  e_id = '0;
    logic [3:0]  e_len = '0;
    logic [63:0] e_data = '0;
    logic        e_full = 0, e_ovr = 0;

    always #2 clk = ~clk;

    lin_rxbuf_ovr uut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ok(frm_ok),
        .frm_id(frm_id), .frm_len(frm_len), .frm_data(frm_data),
        .sw_release(sw_release), .ovr_clear(ovr_clear), .lock_mode(lock_mode),
        .buf_id(buf_id), .buf_len(buf_len), .buf_data(buf_data),
        .buf_full(buf_full), .ovr_flag(ovr_flag)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pattern(input int seed);
        logic [63:0] d;
        for (int k = 0; k < 8; k++) d[k*8 +: 8] = 8'((seed * 37 + k * 29 + 5) | 1);
        return d;
    endfunction

    function automatic logic [63:0] keep_bytes(input logic [63:0] d, input int len);
        logic [63:0] r = '0;
        for (int k = 0; k < 8; k++) if (k < len) r[k*8 +: 8] = d[k*8 +: 8];
        return r;
    endfunction

    // One cycle of stimulus, driven at a negedge; the model follows the requirements
    task automatic step(input bit v, input bit ok, input logic [5:0] id, input int len,
                        input logic [63:0] d, input bit rel, input bit clr, input bit lk);
        bit good, fe;
        frm_valid = v; frm_ok = ok; frm_id = id; frm_len = 4'(len); frm_data = d;
        sw_release = rel; ovr_clear = clr; lock_mode = lk;
        good = v && ok;
        fe = e_full && !rel;
        if (good && (!fe || !lk)) begin
            e_id = id; e_len = 4'(len); e_data = keep_bytes(d, len);
        end
        e_ovr  = (good && fe) || (e_ovr && !clr);
        e_full = fe || good;
        @(negedge clk);
        frm_valid = 0; frm_ok = 0; sw_release = 0; ovr_clear = 0;
    endtask

    task automatic check_all(input string req);
        check(req, 64'(buf_id),   64'(e_id));
        check(req, 64'(buf_len),  64'(e_len));
        check(req, buf_data,      e_data);
        check(req, 64'(buf_full), 64'(e_full));
        check(req, 64'(ovr_flag), 64'(e_ovr));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {buf_id, buf_len, 2'b0, buf_full, ovr_flag}, 64'd0);
        check("R1", buf_data, 64'd0);
        rst_n = 1;
        @(negedge clk);

        for (int lk = 0; lk < 2; lk++) begin
            for (int len = 1; len <= 8; len++) begin
                step(1, 1, 6'(len + lk * 16), len, pattern(len + lk * 8), 0, 0, lk[0]);
                check_all("R2 R9");
                step(1, 1, 6'(40 + len), 9 - len, pattern(100 + len), 0, 0, lk[0]);
                check_all(lk != 0 ? "R3 R5" : "R3 R4");
                step(0, 0, 0, 0, 0, 0, 1, lk[0]);
                check_all("R7");
                step(0, 0, 0, 0, 0, 1, 0, lk[0]);
                check_all("R6");
            end
        end

        // Release and frame together: accepted, no overrun (R6)
        step(1, 1, 6'd7, 3, pattern(7), 0, 0, 1);
        step(1, 1, 6'd9, 5, pattern(9), 1, 0, 1);
        check_all("R6");
        check("R6", 64'(ovr_flag), 64'd0);

        // Rejected frame while full changes nothing (R8)
        step(1, 0, 6'd33, 8, pattern(33), 0, 0, 0);
        check_all("R8");
        check("R8", 64'(ovr_flag), 64'd0);

        // Clear and overrun in the same cycle: flag stays set (R7)
        step(1, 1, 6'd11, 2, pattern(11), 0, 0, 0);
        check_all("R3");
        step(1, 1, 6'd12, 4, pattern(12), 0, 1, 0);
        check_all("R7");
        check("R7", 64'(ovr_flag), 64'd1);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        check_all("R7");
        step(0, 0, 0, 0, 0, 0, 1, 0);
        check("R7", 64'(ovr_flag), 64'd0);

        // Rejected frame into an empty buffer is not stored (R8)
        step(0, 0, 0, 0, 0, 1, 0, 0);
        step(1, 0, 6'd50, 6, pattern(50), 0, 0, 0);
        check_all("R8");
        check("R8", 64'(buf_full), 64'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule